// File: doc/BRIEF.md
# Adaptive-Depth Register-Exchange Survivor Memory

This block holds the survivor paths of a 64-state Viterbi decoder in register-exchange form. Each clock it takes the survivor decisions for two trellis stages, as a two-step (radix-2x2) add-compare-select array produces them. It appends a pair of decoded bits to every state's path row and shifts the oldest pair of state 0's row out as the decoded result. The path row of every state is split into pair columns, one column per clock, and 32 columns cover 64 trellis stages.

A merge detector looks at the path rows of the first 48 states in groups of four. The four states of a group are the four two-step predecessors of one state. For each column it decides whether every checked group holds one common value. The column nearest the input side where this holds is the merge column. Past that column the rows of states other than 0 keep their value, and state 0's row shifts straight toward the output instead of exchanging. The survivor depth that is actively exchanged therefore shrinks when the paths merge early. The per-column enables are brought out so that clock-gating cells outside the block can use them.

Top module: `vt_survivor_mem`

## Requirements
- R1: While rst_ni is low, all path registers are zero, valid_o is 0, dout_o is 0, found_o is 1, merge_stage_o is 3 and gate_o is 32'h0000000F.
- R2: valid_o is 0 for the first 31 rising clock edges after rst_ni rises and is 1 from the 32nd edge on.
- R3: For each state ns (6 bits, where the newest input bit enters at bit 5), the column 0 pair becomes {ns[4], ns[5]}. When column j>0 exchanges, it takes column j-1 of source state {ns[3:0], b, a}, where b = dec_b_i[ns] and a = dec_a_i[{ns[4:0], b}].
- R4: dout_o is the last column (31) of state 0's row. Bit 1 is the bit of the earlier trellis stage of the pair.
- R5: Only columns 3 to 31 are examined. A column is merged when, within every group {4g..4g+3} for g = 0..11, all four rows hold equal pairs. found_o is 1 and merge_stage_o names the lowest merged column.
- R6: When no examined column is merged, found_o is 0, merge_stage_o is 0 and every gate_o bit is 1, so all columns exchange.
- R7: With a merge at column m, gate_o[j] is 1 exactly for j <= m. In each column j > m, the rows of states 1..63 hold and state 0 takes its own column j-1. As a consequence, a merged region that is newly invaded by unmerged data moves the merge column one step toward the output per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_a_i | input | 64 | First-stage decisions, indexed by intermediate state |
| dec_b_i | input | 64 | Second-stage decisions, indexed by final state |
| dout_o | output | 2 | Decoded bit pair from state 0, bit 1 older |
| valid_o | output | 1 | Memory has filled since reset |
| found_o | output | 1 | A merged column was found |
| merge_stage_o | output | 5 | Lowest merged column, 0 when none |
| gate_o | output | 32 | Per-column enable for rows of states 1..63 |

## Verification
Exchange into the merge column and direct shift just past it happen in the same clock whenever unmerged data reaches a merged region. The bench provokes this by running all-zero decisions until columns 4 and up hold frozen equal rows. It then switches both decision vectors to an alternating pattern that never merges. This pattern must make merge_stage_o step from 4 by exactly one per clock, until found_o drops after the 29th edge. The constant-decision runs judge the source mapping and the bit order through dout_o after the memory has flushed.

// File: rtl/vt_sm_pkg.sv
package vt_sm_pkg;
  typedef logic [1:0] pair_t;
endpackage

// File: rtl/vt_sm_fill.sv
module vt_sm_fill #(
  parameter int NP = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  localparam int CW = $clog2(NP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != CW'(NP)) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == CW'(NP));

  a_r2_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/vt_sm_array.sv
module vt_sm_array
  import vt_sm_pkg::*;
#(
  parameter int NS  = 64,
  parameter int NP  = 32,
  parameter int CHK = 48,
  parameter int MC  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] dec_a_i,
  input  logic [NS-1:0] dec_b_i,
  input  logic [NP-1:0] gate_i,
  output pair_t         chk_o [CHK][NP-MC],
  output pair_t         dout_o
);
  localparam int SW = $clog2(NS);

  pair_t row_w [NS][NP];

  for (genvar s = 0; s < NS; s++) begin : g_st
    localparam logic [SW-1:0] SI = SW'(s);
    logic          sel_b, sel_a;
    logic [SW-1:0] mid_idx, src_idx;

    assign sel_b   = dec_b_i[s];
    assign mid_idx = {SI[SW-2:0], sel_b};
    assign sel_a   = dec_a_i[mid_idx];
    assign src_idx = {SI[SW-3:0], sel_b, sel_a};

    for (genvar j = 0; j < NP; j++) begin : g_col
      pair_t cell_q, cell_d;
      logic  cell_en;
      if (j == 0) begin : g_head
        assign cell_d  = {SI[SW-2], SI[SW-1]};
        assign cell_en = gate_i[0];
      end else if (s == 0) begin : g_zero
        // state 0 always clocked; direct shift past the merge column
        assign cell_d  = gate_i[j] ? row_w[src_idx][j-1] : row_w[0][j-1];
        assign cell_en = 1'b1;
      end else begin : g_other
        assign cell_d  = row_w[src_idx][j-1];
        assign cell_en = gate_i[j];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cell_q <= '0;
        else if (cell_en) cell_q <= cell_d;
      end
      assign row_w[s][j] = cell_q;
    end
  end

  for (genvar s = 0; s < CHK; s++) begin : g_chk_s
    for (genvar c = 0; c < NP - MC; c++) begin : g_chk_c
      assign chk_o[s][c] = row_w[s][c+MC];
    end
  end

  assign dout_o = row_w[0][NP-1];

  a_r7_frozen_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i[NP-1] |=> $stable(row_w[1][NP-1]));

  a_r7_direct_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i[NP-1] |=> (row_w[0][NP-1] == $past(row_w[0][NP-2])));
endmodule

// File: rtl/vt_sm_merge_det.sv
module vt_sm_merge_det
  import vt_sm_pkg::*;
#(
  parameter int NP  = 32,
  parameter int CHK = 48,
  parameter int MC  = 3,
  parameter int GRP = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  pair_t                 chk_i [CHK][NP-MC],
  output logic                  found_o,
  output logic [$clog2(NP)-1:0] stage_o,
  output logic [NP-1:0]         gate_o
);
  localparam int NC    = NP - MC;
  localparam int NG    = CHK / GRP;
  localparam int STG_W = $clog2(NP);

  logic [NC-1:0] col_eq;

  for (genvar c = 0; c < NC; c++) begin : g_c
    logic [NG-1:0] grp_eq;
    for (genvar g = 0; g < NG; g++) begin : g_g
      always_comb begin
        grp_eq[g] = 1'b1;
        for (int k = 1; k < GRP; k++)
          if (chk_i[g*GRP+k][c] != chk_i[g*GRP][c]) grp_eq[g] = 1'b0;
      end
    end
    assign col_eq[c] = &grp_eq;
  end

  // lowest merged column wins
  always_comb begin
    found_o = 1'b0;
    stage_o = '0;
    for (int c = NC - 1; c >= 0; c--) begin
      if (col_eq[c]) begin
        found_o = 1'b1;
        stage_o = STG_W'(c + MC);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NP; j++)
      gate_o[j] = !found_o || (j <= int'(stage_o));
  end

  a_r5_stage_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (int'(stage_o) >= MC));

  a_r7_gate_at_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> gate_o[stage_o]);

  a_r6_open_when_unmerged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> (&gate_o && stage_o == '0));
endmodule

// File: rtl/vt_survivor_mem.sv
module vt_survivor_mem
  import vt_sm_pkg::*;
#(
  parameter int NUM_STATES   = 64,
  parameter int MAX_TRUNC    = 64,
  parameter int CHECK_STATES = 48,
  localparam int NP    = MAX_TRUNC / 2,
  localparam int STG_W = $clog2(NP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_STATES-1:0] dec_a_i,
  input  logic [NUM_STATES-1:0] dec_b_i,
  output logic [1:0]       dout_o,
  output logic             valid_o,
  output logic             found_o,
  output logic [STG_W-1:0] merge_stage_o,
  output logic [NP-1:0]    gate_o
);
  localparam int SW = $clog2(NUM_STATES);
  localparam int MC = SW / 2;  // columns still carrying state index bits

  pair_t chk_w [CHECK_STATES][NP-MC];
  pair_t dout_w;

  vt_sm_array #(
    .NS (NUM_STATES),
    .NP (NP),
    .CHK(CHECK_STATES),
    .MC (MC)
  ) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_a_i(dec_a_i),
    .dec_b_i(dec_b_i),
    .gate_i (gate_o),
    .chk_o  (chk_w),
    .dout_o (dout_w)
  );

  vt_sm_merge_det #(
    .NP (NP),
    .CHK(CHECK_STATES),
    .MC (MC),
    .GRP(4)
  ) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chk_i  (chk_w),
    .found_o(found_o),
    .stage_o(merge_stage_o),
    .gate_o (gate_o)
  );

  vt_sm_fill #(.NP(NP)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_o(valid_o)
  );

  assign dout_o = dout_w;
endmodule

// File: tb/vt_survivor_mem_tb.sv
module vt_survivor_mem_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dec_a = '0, dec_b = '0;
  logic [1:0]  dout;
  logic        valid, found;
  logic [4:0]  stage;
  logic [31:0] gate;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vt_survivor_mem u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dec_a_i(dec_a), .dec_b_i(dec_b),
    .dout_o(dout), .valid_o(valid), .found_o(found),
    .merge_stage_o(stage), .gate_o(gate)
  );

  function automatic logic [31:0] gmask(int m);
    return 32'((64'd1 << (m + 1)) - 64'd1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dec_a = '0; dec_b = '0;
    #5;
    chk("R1 valid", 32'(valid), 0);
    chk("R1 dout", 32'(dout), 0);
    chk("R1 found", 32'(found), 1);
    chk("R1 stage", 32'(stage), 3);
    chk("R1 gate", gate, 32'h0000000F);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    do_reset();
    step(31);
    chk("R2 not yet valid", 32'(valid), 0);
    step(1);
    chk("R2 valid at 32", 32'(valid), 1);
    chk("R4 zero path out", 32'(dout), 0);
    chk("R5 zero run stage", 32'(stage), 3);
  endtask

  task automatic t_walk();
    // zeros have been running since reset; columns 4+ of rows 1..63 frozen at 0
    dec_a = 64'hAAAA_AAAA_AAAA_AAAA;
    dec_b = 64'hAAAA_AAAA_AAAA_AAAA;
    step(1);
    chk("R7 walk found 1", 32'(found), 1);
    chk("R7 walk stage 4", 32'(stage), 4);
    step(5);
    chk("R7 walk stage 9", 32'(stage), 9);
    chk("R7 gate at 9", gate, gmask(9));
    chk("R7 direct shift dout", 32'(dout), 0);
    step(22);
    chk("R7 walk stage 31", 32'(stage), 31);
    step(1);
    chk("R6 no merge found", 32'(found), 0);
    chk("R6 stage zero", 32'(stage), 0);
    chk("R6 all gates open", gate, 32'hFFFF_FFFF);
    step(10);
    chk("R6 stays unmerged", 32'(found), 0);
    chk("R3 alt pattern state0 path", 32'(dout), 0);
  endtask

  task automatic t_map();
    do_reset();
    dec_b = '1; dec_a = '0;
    step(40);
    chk("R3 b=1 a=0 dout", 32'(dout), 2'b01);
    chk("R5 const merge at 3", 32'(stage), 3);
    dec_b = '0; dec_a = '1;
    step(40);
    chk("R4 b=0 a=1 dout order", 32'(dout), 2'b10);
    dec_b = '1; dec_a = '1;
    step(40);
    chk("R3 all ones dout", 32'(dout), 2'b11);
    chk("R2 valid held", 32'(valid), 1);
  endtask

  initial begin
    t_fill();
    t_walk();
    t_map();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule